// File: doc/BRIEF.md
# DMA Interrupt Status Register with Stacked Clear-on-Read

This block collects interrupt conditions raised by a DMA engine and presents them to a host as one 8-bit status word. Each condition sets a sticky bit. Each of bits 6 to 2 can be enabled separately, and the enabled set bits drive one interrupt line. When the host reads the word, the read clears only the bits that were visible at that moment. Conditions that arrive while their bit is already set, or in the same cycle as a read, wait in a one-deep stack. They are promoted into the status word one cycle after the read, so no event is lost between reads.

Bit 7 is not sticky. It follows the FIFO-empty level, and it can never raise the interrupt. The parity bit has its own enable that blocks it from setting at all. The bus-fault bit can set only while the engine is bus master. After each accepted read, a guard window keeps the read port busy. A read during that window returns the word captured earlier and changes nothing.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, the read data is 0x80, the interrupt output is low and the busy output is low.
- R2: Bit 7 returns the registered FIFO-empty input level at the time of the read. It never asserts the interrupt output, whatever the enables are.
- R3: Bit 6 sets on a master parity error or a target-reported parity error, but only while the parity enable input is high. With the enable low, neither event has any effect.
- R4: Bit 5 sets on a bad-address or target-abort event only while the master input is high.
- R5: Bits 4, 3 and 2 set on the abort, single-step and script-interrupt events respectively. Bits 1 and 0 always read 0.
- R6: An accepted read returns the word present at the read edge and clears every set bit. The interrupt output is low in the cycle after the read.
- R7: An event whose bit is already set, or that arrives in the cycle of a read, is held in the stack. It appears in the status word one cycle after the read and is reported by the next read.
- R8: The interrupt output is the OR of status bits 6..0 that are set and whose enable bit (enable bit i gates status bit i) is high. Enable changes take effect without a clock edge.
- R9: After an accepted read, busy is high for exactly GUARD_CLKS cycles. A read strobe during that window leaves the read data and the status bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_empty_i | input | 1 | FIFO-empty level from the DMA engine |
| par_enable_i | input | 1 | Enables the parity status bit |
| mst_par_err_i | input | 1 | Data parity error seen as master (pulse) |
| tgt_par_err_i | input | 1 | Parity error reported by the target (pulse) |
| is_master_i | input | 1 | Engine currently owns the bus |
| bad_addr_i | input | 1 | Cycle ended with a bad address (pulse) |
| tgt_abort_i | input | 1 | Cycle ended with a target abort (pulse) |
| abort_i | input | 1 | Operation aborted (pulse) |
| single_step_i | input | 1 | Single-step event (pulse) |
| script_int_i | input | 1 | Script interrupt event (pulse) |
| irq_enable_i | input | 7 | Per-bit interrupt enables for status bits 6..0 |
| rd_strobe_i | input | 1 | Host read request, one cycle |
| rd_data_o | output | 8 | Status word captured by the last accepted read |
| rd_busy_o | output | 1 | Guard window active; reads are ignored |
| int_pend_o | output | 1 | Interrupt pending summary / interrupt line |

## Verification
The bench builds the block with the default guard length of 12 cycles. With that length, the busy output can be checked on both sides of its last cycle, and a read attempted inside the window can be shown to leave the captured data and the pending status unchanged. Because the window is this long, a stacked event can also be observed being promoted one cycle after a read and then reported by the following read.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int STAT_W    = 8;
  localparam int STICKY_W  = 7;
  localparam int IDX_FIFO  = 7;
  localparam int IDX_PAR   = 6;
  localparam int IDX_FAULT = 5;
  localparam int IDX_ABORT = 4;
  localparam int IDX_STEP  = 3;
  localparam int IDX_SCRIPT = 2;
  localparam logic [STAT_W-1:0] RESET_WORD = 8'h80;
  typedef logic [STICKY_W-1:0] sticky_t;
endpackage

// File: rtl/dma_irq_event_map.sv
module dma_irq_event_map
  import dma_irq_pkg::*;
(
  input  logic    par_enable,
  input  logic    mst_par_err,
  input  logic    tgt_par_err,
  input  logic    is_master,
  input  logic    bad_addr,
  input  logic    tgt_abort,
  input  logic    abort_ev,
  input  logic    step_ev,
  input  logic    script_ev,
  output sticky_t ev_vec
);
  always_comb begin
    ev_vec             = '0;
    ev_vec[IDX_PAR]    = par_enable & (mst_par_err | tgt_par_err);
    ev_vec[IDX_FAULT]  = is_master & (bad_addr | tgt_abort);
    ev_vec[IDX_ABORT]  = abort_ev;
    ev_vec[IDX_STEP]   = step_ev;
    ev_vec[IDX_SCRIPT] = script_ev;
  end
endmodule

// File: rtl/dma_irq_stack_reg.sv
module dma_irq_stack_reg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         rd_acc,
  input  logic [W-1:0] ev_vec,
  output logic [W-1:0] status_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic st_q;
    logic sk_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        st_q <= 1'b0;
        sk_q <= 1'b0;
      end else if (rd_acc) begin
        st_q <= 1'b0;
        sk_q <= sk_q | ev_vec[i];
      end else begin
        st_q <= st_q | sk_q | ev_vec[i];
        sk_q <= (sk_q | ev_vec[i]) & st_q;
      end
    end
    assign status_o[i] = st_q;
  end
endmodule

// File: rtl/dma_irq_read_guard.sv
module dma_irq_read_guard #(
  parameter int GUARD_CLKS = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  output logic rd_acc,
  output logic busy
);
  localparam int CW = $clog2(GUARD_CLKS + 1);
  logic [CW-1:0] cnt_q;

  assign busy   = (cnt_q != '0);
  assign rd_acc = rd_req & ~busy;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (rd_acc) cnt_q <= CW'(GUARD_CLKS);
    else if (busy)   cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int GUARD_CLKS = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fifo_empty_i,
  input  logic                par_enable_i,
  input  logic                mst_par_err_i,
  input  logic                tgt_par_err_i,
  input  logic                is_master_i,
  input  logic                bad_addr_i,
  input  logic                tgt_abort_i,
  input  logic                abort_i,
  input  logic                single_step_i,
  input  logic                script_int_i,
  input  logic [STICKY_W-1:0] irq_enable_i,
  input  logic                rd_strobe_i,
  output logic [STAT_W-1:0]   rd_data_o,
  output logic                rd_busy_o,
  output logic                int_pend_o
);
  sticky_t ev_vec;
  sticky_t status;
  logic    rd_acc;
  logic    fifo_q;

  dma_irq_event_map u_map (
    .par_enable  (par_enable_i),
    .mst_par_err (mst_par_err_i),
    .tgt_par_err (tgt_par_err_i),
    .is_master   (is_master_i),
    .bad_addr    (bad_addr_i),
    .tgt_abort   (tgt_abort_i),
    .abort_ev    (abort_i),
    .step_ev     (single_step_i),
    .script_ev   (script_int_i),
    .ev_vec      (ev_vec)
  );

  dma_irq_read_guard #(.GUARD_CLKS(GUARD_CLKS)) u_guard (
    .clk    (clk),
    .rst    (rst),
    .rd_req (rd_strobe_i),
    .rd_acc (rd_acc),
    .busy   (rd_busy_o)
  );

  dma_irq_stack_reg #(.W(STICKY_W)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .rd_acc   (rd_acc),
    .ev_vec   (ev_vec),
    .status_o (status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_q    <= RESET_WORD[IDX_FIFO];
      rd_data_o <= RESET_WORD;
    end else begin
      fifo_q <= fifo_empty_i;
      if (rd_acc) rd_data_o <= {fifo_q, status};
    end
  end

  assign int_pend_o = |(status & irq_enable_i);
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_strobe,
  input logic [7:0] rd_data,
  input logic       rd_busy,
  input logic       int_pend,
  input logic       rd_acc,
  input logic [6:0] status
);
  assert_reset_word_R1: assert property (@(posedge clk)
    $fell(rst) |-> (rd_data == 8'h80 && !int_pend && !rd_busy));

  assert_no_irq_when_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (status == '0) |-> !int_pend);

  assert_low_bits_zero_R5: assert property (@(posedge clk) disable iff (rst)
    rd_data[1:0] == 2'b00);

  assert_clear_on_read_R6: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> !int_pend);

  assert_guard_starts_R9: assert property (@(posedge clk) disable iff (rst)
    rd_acc |=> rd_busy);

  assert_busy_read_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && rd_busy) |=> $stable(rd_data));
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_strobe (rd_strobe_i),
  .rd_data   (rd_data_o),
  .rd_busy   (rd_busy_o),
  .int_pend  (int_pend_o),
  .rd_acc    (rd_acc),
  .status    (status)
);

// File: tb/tb_dma_irq_status.sv
module tb_dma_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int GUARD = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       fifo_empty = 1'b1, par_en = 1'b1, mst_par = 1'b0, tgt_par = 1'b0;
  logic       is_master = 1'b0, bad_addr = 1'b0, tgt_abort = 1'b0;
  logic       abort_ev = 1'b0, step_ev = 1'b0, script_ev = 1'b0;
  logic [6:0] enable = 7'h7F;
  logic       rd = 1'b0;
  logic [7:0] rd_data;
  logic       busy, pend;
  int         n_checks = 0, n_fail = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status #(.GUARD_CLKS(GUARD)) dut (
    .clk(clk), .rst(rst), .fifo_empty_i(fifo_empty), .par_enable_i(par_en),
    .mst_par_err_i(mst_par), .tgt_par_err_i(tgt_par), .is_master_i(is_master),
    .bad_addr_i(bad_addr), .tgt_abort_i(tgt_abort), .abort_i(abort_ev),
    .single_step_i(step_ev), .script_int_i(script_ev), .irq_enable_i(enable),
    .rd_strobe_i(rd), .rd_data_o(rd_data), .rd_busy_o(busy), .int_pend_o(pend)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    case (which)
      0: mst_par = 1'b1;   1: tgt_par = 1'b1;  2: bad_addr = 1'b1;
      3: tgt_abort = 1'b1; 4: abort_ev = 1'b1; 5: step_ev = 1'b1;
      default: script_ev = 1'b1;
    endcase
    @(negedge clk);
    {mst_par, tgt_par, bad_addr, tgt_abort, abort_ev, step_ev, script_ev} = '0;
  endtask

  task automatic do_read(output logic [7:0] d);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    d = rd_data;
  endtask

  task automatic read_expect(input string req, input logic [7:0] exp);
    logic [7:0] d;
    do_read(d);
    chk(req, d, exp);
    step(GUARD);
  endtask

  task automatic t_fifo_R2();
    fifo_empty = 1'b0; step(1);
    read_expect("R2 fifo low", 8'h00);
    fifo_empty = 1'b1; step(1);
    chk("R2 no irq from fifo", pend, 1'b0);
    read_expect("R2 fifo high", 8'h80);
    fifo_empty = 1'b0; step(1);
  endtask

  task automatic t_parity_R3();
    par_en = 1'b0; pulse(0); pulse(1);
    chk("R3 gated pend", pend, 1'b0);
    read_expect("R3 gated", 8'h00);
    par_en = 1'b1; pulse(1);
    chk("R3 tgt pend", pend, 1'b1);
    read_expect("R3 tgt", 8'h40);
    pulse(0);
    read_expect("R3 master", 8'h40);
  endtask

  task automatic t_fault_R4();
    is_master = 1'b0; pulse(2); pulse(3);
    read_expect("R4 not master", 8'h00);
    is_master = 1'b1; pulse(2);
    read_expect("R4 bad addr", 8'h20);
    pulse(3);
    read_expect("R4 tgt abort", 8'h20);
  endtask

  task automatic t_generic_R5();
    pulse(4); pulse(5); pulse(6);
    read_expect("R5 abort step script", 8'h1C);
  endtask

  task automatic t_clear_R6();
    logic [7:0] d;
    pulse(6);
    chk("R6 pend before", pend, 1'b1);
    do_read(d);
    chk("R6 snapshot", d, 8'h04);
    chk("R6 pend cleared", pend, 1'b0);
    step(GUARD);
    read_expect("R6 empty after", 8'h00);
  endtask

  task automatic t_stack_R7();
    logic [7:0] d;
    pulse(4); pulse(4);
    do_read(d);
    chk("R7 first read", d, 8'h10);
    chk("R7 clear moment", pend, 1'b0);
    step(1);
    chk("R7 promoted", pend, 1'b1);
    step(GUARD - 1);
    read_expect("R7 stacked read", 8'h10);
    read_expect("R7 drained", 8'h00);
    rd = 1'b1; step_ev = 1'b1;
    @(negedge clk);
    rd = 1'b0; step_ev = 1'b0;
    chk("R7 same-cycle read data", rd_data, 8'h00);
    chk("R7 same-cycle pend", pend, 1'b0);
    step(1);
    chk("R7 same-cycle promoted", pend, 1'b1);
    step(GUARD - 1);
    read_expect("R7 same-cycle reported", 8'h08);
  endtask

  task automatic t_mask_R8();
    enable = 7'h00; pulse(5);
    chk("R8 all masked", pend, 1'b0);
    enable = 7'h08; #1;
    chk("R8 bit3 enabled", pend, 1'b1);
    enable = 7'h10; #1;
    chk("R8 other bit enabled", pend, 1'b0);
    enable = 7'h7F;
    step(1);
    read_expect("R8 status kept", 8'h08);
  endtask

  task automatic t_guard_R9();
    logic [7:0] d;
    pulse(6);
    do_read(d);
    chk("R9 first read", d, 8'h04);
    chk("R9 busy starts", busy, 1'b1);
    pulse(4);
    do_read(d);
    chk("R9 busy read holds data", d, 8'h04);
    chk("R9 busy read keeps status", pend, 1'b1);
    step(GUARD - 3);
    chk("R9 last busy cycle", busy, 1'b1);
    step(1);
    chk("R9 busy ends", busy, 1'b0);
    read_expect("R9 after window", 8'h10);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    chk("R1 reset data", rd_data, 8'h80);
    chk("R1 reset pend", pend, 1'b0);
    chk("R1 reset busy", busy, 1'b0);
    t_fifo_R2();
    t_parity_R3();
    t_fault_R4();
    t_generic_R5();
    t_clear_R6();
    t_stack_R7();
    t_mask_R8();
    t_guard_R9();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule